// File: doc/BRIEF.md
# Deferred Invalidation Queue with Load Fence

This block sits beside one core's private cache. Other cores send it requests to invalidate cache lines. The block acknowledges each request in the same cycle it arrives and stores the line address in a small FIFO. It then drains the FIFO into the cache's invalidate port, one line per cycle, in the cycles when that port is not busy serving a load. While an invalidation waits in the FIFO, local loads may still hit the stale line. That is allowed as long as no fence is pending.

A read-fence input marks every invalidation held in the FIFO at that moment. From the next cycle on, a load-stall output holds later loads back until each marked invalidation has reached the cache. Invalidations that arrive with the fence or after it are not marked and do not lengthen the stall. When the FIFO is full, the acknowledgement is withheld, and the requester must hold its request until there is room.

Top module: `inval_defer_queue`

## Requirements
- R1: A request (`inv_req_valid` = 1) is acknowledged through `inv_ack` in the same cycle while the FIFO holds fewer than DEPTH entries. This holds whether or not the cache port is busy.
- R2: With DEPTH entries stored, `inv_ack` stays 0 and the request is not stored. An address offered only in that cycle never appears on the invalidate port.
- R3: In every cycle where the FIFO is non-empty and `cache_busy` is 0, exactly one stored address is driven with `cache_inv_valid` = 1. Addresses leave in arrival order.
- R4: While `cache_busy` is 1, `cache_inv_valid` stays 0 and the FIFO contents are kept.
- R5: If no fence has been raised, `load_stall` stays 0 however many invalidations are queued, including a full FIFO.
- R6: A cycle with `rd_barrier` = 1 marks every entry stored at the start of that cycle. `load_stall` is 1 from the next cycle until the cycle after the last marked entry is applied.
- R7: An entry pushed in the fence cycle or later is unmarked. Once all marked entries are applied, `load_stall` returns to 0 even while unmarked entries remain queued.
- R8: A second fence while the stall is pending also marks the entries stored at that time, so the stall lasts until those are applied as well.
- R9: A fence raised while the FIFO is empty, or while its only entry is applied in that same cycle, does not raise `load_stall`.
- R10: After reset the FIFO is empty and `cache_inv_valid` and `load_stall` are 0. A reset during a pending fence clears the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inv_req_valid | input | 1 | Incoming invalidate request |
| inv_req_addr | input | AW | Line address to invalidate |
| inv_ack | output | 1 | Request accepted this cycle |
| cache_busy | input | 1 | Cache port is serving a load this cycle |
| cache_inv_valid | output | 1 | Apply an invalidation this cycle |
| cache_inv_addr | output | AW | Line address being invalidated |
| rd_barrier | input | 1 | Read fence: mark queued invalidations |
| load_stall | output | 1 | Hold back local loads |

## Verification
The bench provokes two kinds of same-cycle collision. In the first, a fence arrives in the same cycle the FIFO head is drained. In the second, a fence, a new push and a drain all land in one cycle. In both cases the expected result is that neither the entry being applied nor the entry being pushed holds the stall, so `load_stall` must stay 0 in the following cycle. A second fence raised while a stall is pending must keep the stall up until the entry that fence marked has left; the vector right after the first fence's last marked entry is applied tells the two behaviours apart.

// File: rtl/ivq_pkg.sv
package ivq_pkg;

   // Policy for accepting a request while the FIFO is full
   typedef enum logic {
      IVQ_FULL_STRICT = 1'b0,  // a full FIFO never accepts
      IVQ_FULL_PASS   = 1'b1   // a drain in the same cycle frees a slot
   } ivq_full_e;

   localparam int IVQ_DEF_AW    = 8;
   localparam int IVQ_DEF_DEPTH = 8;

endpackage

// File: rtl/ivq_ring.sv
module ivq_ring #(
   parameter int AW    = 8,
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [AW-1:0]    push_addr,
   input  logic             pop,
   output logic [AW-1:0]    head_addr,
   output logic [PW-1:0]    head_idx,
   output logic [CW-1:0]    occ,
   output logic             full,
   output logic             empty,
   output logic [DEPTH-1:0] slot_valid
);

   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;
   logic [AW-1:0] slot_addr [DEPTH];

   // One storage cell per slot, each with its own occupancy bit
   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_addr[s]  <= '0;
            slot_valid[s] <= 1'b0;
         end else begin
            if (push && (wr_ptr == PW'(s))) begin
               slot_addr[s]  <= push_addr;
               slot_valid[s] <= 1'b1;
            end else if (pop && (rd_ptr == PW'(s))) begin
               slot_valid[s] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         occ <= occ + CW'(push) - CW'(pop);
      end
   end

   assign head_addr = slot_addr[rd_ptr];
   assign head_idx  = rd_ptr;
   assign full      = (occ == CW'(DEPTH));
   assign empty     = (occ == '0);

endmodule

// File: rtl/ivq_tagger.sv
module ivq_tagger #(
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             barrier,
   input  logic             pop,
   input  logic [PW-1:0]    head_idx,
   input  logic [DEPTH-1:0] slot_valid,
   input  logic [CW-1:0]    occ,
   output logic [DEPTH-1:0] tag_vec,
   output logic [CW-1:0]    tag_cnt,
   output logic             stall
);

   // Fence mark per slot. The mark reflects occupancy before this
   // cycle's push, so an entry arriving with the fence stays unmarked.
   for (genvar s = 0; s < DEPTH; s++) begin : g_tag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tag_vec[s] <= 1'b0;
         else if (pop && (head_idx == PW'(s)))
            tag_vec[s] <= 1'b0;
         else if (barrier && slot_valid[s])
            tag_vec[s] <= 1'b1;
      end
   end

   // Marked entries always form the oldest part of the FIFO, so on a
   // fence the count becomes the occupancy less any entry drained now.
   logic          head_marked;
   logic [CW-1:0] cnt_next;

   assign head_marked = tag_vec[head_idx];

   always_comb begin
      if (barrier)
         cnt_next = occ - CW'(pop);
      else
         cnt_next = tag_cnt - CW'(pop && head_marked);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_cnt <= '0;
      else        tag_cnt <= cnt_next;
   end

   assign stall = (tag_cnt != '0);

endmodule

// File: rtl/ivq_issue.sv
module ivq_issue
   import ivq_pkg::*;
#(
   parameter ivq_full_e FULL_POLICY = IVQ_FULL_STRICT
) (
   input  logic inv_req_valid,
   input  logic cache_busy,
   input  logic full,
   input  logic empty,
   output logic inv_ack,
   output logic push,
   output logic pop
);

   logic room;

   assign pop = !empty && !cache_busy;

   if (FULL_POLICY == IVQ_FULL_PASS) begin : g_pass
      assign room = !full || pop;
   end else begin : g_strict
      assign room = !full;
   end

   assign inv_ack = inv_req_valid && room;
   assign push    = inv_ack;

endmodule

// File: rtl/inval_defer_queue.sv
module inval_defer_queue
   import ivq_pkg::*;
#(
   parameter int        AW          = IVQ_DEF_AW,
   parameter int        DEPTH       = IVQ_DEF_DEPTH,
   parameter ivq_full_e FULL_POLICY = IVQ_FULL_STRICT,
   localparam int       PW          = $clog2(DEPTH),
   localparam int       CW          = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inv_req_valid,
   input  logic [AW-1:0] inv_req_addr,
   output logic          inv_ack,
   input  logic          cache_busy,
   output logic          cache_inv_valid,
   output logic [AW-1:0] cache_inv_addr,
   input  logic          rd_barrier,
   output logic          load_stall
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("inval_defer_queue: DEPTH must be a power of two, at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("inval_defer_queue: AW must be at least 1");
   end

   logic             push;
   logic             pop;
   logic             full;
   logic             empty;
   logic [AW-1:0]    head_addr;
   logic [PW-1:0]    head_idx;
   logic [CW-1:0]    occ;
   logic [DEPTH-1:0] slot_valid;
   logic [DEPTH-1:0] tag_vec;
   logic [CW-1:0]    tag_cnt;

   ivq_issue #(
      .FULL_POLICY(FULL_POLICY)
   ) u_issue (
      .inv_req_valid(inv_req_valid),
      .cache_busy   (cache_busy),
      .full         (full),
      .empty        (empty),
      .inv_ack      (inv_ack),
      .push         (push),
      .pop          (pop)
   );

   ivq_ring #(
      .AW   (AW),
      .DEPTH(DEPTH)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (inv_req_addr),
      .pop       (pop),
      .head_addr (head_addr),
      .head_idx  (head_idx),
      .occ       (occ),
      .full      (full),
      .empty     (empty),
      .slot_valid(slot_valid)
   );

   ivq_tagger #(
      .DEPTH(DEPTH)
   ) u_tagger (
      .clk       (clk),
      .rst_n     (rst_n),
      .barrier   (rd_barrier),
      .pop       (pop),
      .head_idx  (head_idx),
      .slot_valid(slot_valid),
      .occ       (occ),
      .tag_vec   (tag_vec),
      .tag_cnt   (tag_cnt),
      .stall     (load_stall)
   );

   assign cache_inv_valid = pop;
   assign cache_inv_addr  = head_addr;

endmodule

// File: rtl/ivq_checker.sv
module ivq_checker
   import ivq_pkg::*;
#(
   parameter int        AW          = 8,
   parameter int        DEPTH       = 8,
   parameter ivq_full_e FULL_POLICY = IVQ_FULL_STRICT,
   localparam int       CW          = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inv_req_valid,
   input logic             inv_ack,
   input logic             cache_busy,
   input logic             cache_inv_valid,
   input logic             rd_barrier,
   input logic             load_stall,
   input logic [CW-1:0]    occ,
   input logic [DEPTH-1:0] tag_vec,
   input logic [CW-1:0]    tag_cnt
);

   // R1: room in the FIFO means an acknowledgement in the same cycle
   a_r1_ack_when_room: assert property (@(posedge clk) disable iff (!rst_n)
      inv_req_valid && (int'(occ) < DEPTH) |-> inv_ack);

   // R2: a full FIFO withholds the acknowledgement (strict policy)
   a_r2_no_ack_full: assert property (@(posedge clk) disable iff (!rst_n)
      (FULL_POLICY == IVQ_FULL_STRICT) && (int'(occ) == DEPTH) |-> !inv_ack);

   // R2: occupancy never exceeds the depth
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= DEPTH);

   // R3: each application removes exactly one entry
   a_r3_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cache_inv_valid |=> int'(occ) == int'($past(occ)) - 1 + int'($past(inv_ack)));

   // R4: a busy cache port receives no invalidation
   a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cache_busy |-> !cache_inv_valid);

   // R5: without a fence, the stall cannot start
   a_r5_no_fence_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !load_stall && !rd_barrier |=> !load_stall);

   // R6: the stall can only end on a cycle that applies an invalidation
   a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      load_stall && !cache_inv_valid |=> load_stall);

   // R6: the marked count agrees with the per-slot marks
   a_r6_tag_count: assert property (@(posedge clk) disable iff (!rst_n)
      int'(tag_cnt) == $countones(tag_vec));

   // R7: marked entries never outnumber the stored entries
   a_r7_tags_within_occ: assert property (@(posedge clk) disable iff (!rst_n)
      int'(tag_cnt) <= int'(occ));

   // R9: a fence on an empty FIFO raises no stall
   a_r9_empty_fence: assert property (@(posedge clk) disable iff (!rst_n)
      rd_barrier && (occ == '0) |=> !load_stall);

endmodule

bind inval_defer_queue ivq_checker #(
   .AW         (AW),
   .DEPTH      (DEPTH),
   .FULL_POLICY(FULL_POLICY)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .inv_req_valid  (inv_req_valid),
   .inv_ack        (inv_ack),
   .cache_busy     (cache_busy),
   .cache_inv_valid(cache_inv_valid),
   .rd_barrier     (rd_barrier),
   .load_stall     (load_stall),
   .occ            (occ),
   .tag_vec        (tag_vec),
   .tag_cnt        (tag_cnt)
);

// File: tb/inval_defer_queue_tb.sv
module inval_defer_queue_tb;

   localparam int AW     = 8;
   localparam int DEPTH  = 8;
   localparam int NVEC   = 43;
   localparam int WDOG_T = 200000 * 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          inv_req_valid = 1'b0;
   logic [AW-1:0] inv_req_addr = '0;
   logic          inv_ack;
   logic          cache_busy = 1'b0;
   logic          cache_inv_valid;
   logic [AW-1:0] cache_inv_addr;
   logic          rd_barrier = 1'b0;
   logic          load_stall;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   inval_defer_queue #(.AW(AW), .DEPTH(DEPTH)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .inv_req_valid  (inv_req_valid),
      .inv_req_addr   (inv_req_addr),
      .inv_ack        (inv_ack),
      .cache_busy     (cache_busy),
      .cache_inv_valid(cache_inv_valid),
      .cache_inv_addr (cache_inv_addr),
      .rd_barrier     (rd_barrier),
      .load_stall     (load_stall)
   );

   // Fields: req, addr, busy, fence | exp ack, exp valid, exp addr, exp stall
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b1, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // 0  R1 push while busy
      {1'b1, 8'h22, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // 1  R4 held
      {1'b1, 8'h33, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // 2
      {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},  // 3  R6 fence marks 3
      {1'b1, 8'h44, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1},  // 4  R7 unmarked push
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 1'b1},  // 5  R3 order
      {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22, 1'b1},  // 6  R8 second fence
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h33, 1'b1},  // 7
      {1'b1, 8'h55, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1},  // 8  R8 still stalled
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h44, 1'b1},  // 9
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // 10 R7 stall off, 0x55 queued
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0},  // 11
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // 12 empty
      {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},  // 13 R9 fence on empty
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // 14 R9 no stall
      {1'b1, 8'hB0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // 15 fill
      {1'b1, 8'hB1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b1, 8'hB2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b1, 8'hB3, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b1, 8'hB4, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b1, 8'hB5, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b1, 8'hB6, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
      {1'b1, 8'hB7, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // 22 now full
      {1'b1, 8'hB8, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // 23 R2 no ack
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB0, 1'b0},  // 24 R5 full, no stall
      {1'b1, 8'hB9, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // 25 room again
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB1, 1'b0},  // 26
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB2, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB3, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB4, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB5, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB6, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB7, 1'b0},  // 32
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB9, 1'b0},  // 33 R2 0xB8 absent
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // 34
      {1'b1, 8'hC0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // 35
      {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC0, 1'b0},  // 36 R9 fence with drain
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // 37 R9 no stall
      {1'b1, 8'hD0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},  // 38
      {1'b1, 8'hD1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hD0, 1'b0},  // 39 R7 fence+push+drain
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // 40 R7 0xD1 unmarked
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hD1, 1'b0},  // 41
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}   // 42
   };

   task automatic check1(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic req, input logic [AW-1:0] a,
                        input logic busy, input logic bar);
      inv_req_valid = req;
      inv_req_addr  = a;
      cache_busy    = busy;
      rd_barrier    = bar;
   endtask

   initial begin
      // R10: reset state
      drive(1'b0, '0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      #1;
      check1("R10", "inv_valid in reset", AW'(cache_inv_valid), '0);
      check1("R10", "stall in reset", AW'(load_stall), '0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NVEC; k++) begin
         @(negedge clk);
         drive(VEC[k][21], VEC[k][20:13], VEC[k][12], VEC[k][11]);
         #1;
         check1("R1/R2", $sformatf("ack v%0d", k), AW'(inv_ack), AW'(VEC[k][10]));
         check1("R3/R4", $sformatf("inv_valid v%0d", k), AW'(cache_inv_valid), AW'(VEC[k][9]));
         if (VEC[k][9])
            check1("R3", $sformatf("inv_addr v%0d", k), cache_inv_addr, VEC[k][8:1]);
         check1("R5-R9", $sformatf("stall v%0d", k), AW'(load_stall), AW'(VEC[k][0]));
      end

      // R10: reset during a pending fence clears the stall
      @(negedge clk); drive(1'b1, 8'hE0, 1'b1, 1'b0);
      @(negedge clk); drive(1'b1, 8'hE1, 1'b1, 1'b0);
      @(negedge clk); drive(1'b0, 8'h00, 1'b1, 1'b1);
      @(negedge clk); drive(1'b0, 8'h00, 1'b1, 1'b0);
      #1;
      check1("R6", "stall before reset", AW'(load_stall), AW'(1));
      rst_n = 1'b0;
      #1;
      check1("R10", "stall after reset", AW'(load_stall), '0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 8'h00, 1'b0, 1'b0);
      #1;
      check1("R10", "queue empty after reset", AW'(cache_inv_valid), '0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(WDOG_T);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule